// File: doc/BRIEF.md
# Programmable-Oversampling Baud Generator

This block turns one source clock into the timing enables a serial transmitter and receiver need. A prescale counter divides the source clock by a 16-bit divisor to give a sample strobe. A second counter groups sample strobes into bit periods, with a programmable oversampling ratio, and marks both the end of each bit and the middle of each bit. The receiver uses the middle-of-bit strobe for centre sampling.

Software sets the block up through a byte-wide write port with four addresses. The two divisor bytes can only be written while a latch-enable bit in the control register is set. The usual sequence is: set the bit, write the divisor bytes, then clear the bit. The oversampling field uses a compact encoding: zero selects 32, any value from one to eight selects 8, and larger values select themselves. Every accepted change of the divisor or the ratio restarts the counters, so the next period starts cleanly on the new settings.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset loads divisor 1, oversampling field 0 (ratio 32) and latch-enable 0, and clears both counters. From release on, `sample_stb` is high on every cycle, `mid_stb` first fires in cycle 15 and `bit_stb` first fires in cycle 31 (cycles counted from 0, the first cycle after release).
- R2: With an effective divisor D, `sample_stb` is high in one cycle out of every D. A programmed divisor of 0 behaves as D = 1.
- R3: The oversampling field (address 3, bits 4:0) selects ratio N as follows: 0 selects 32, values 1 to 8 select 8, and values 9 to 31 select the field value.
- R4: `bit_stb` fires once every D·N source cycles, always in a cycle where `sample_stb` is also high.
- R5: `mid_stb` fires D·floor(N/2) cycles into each bit period (counted from the period start), always together with `sample_stb` and never together with `bit_stb`.
- R6: Divisor low byte (address 0) and high byte (address 1) are written only while latch-enable (address 2, bit 7) is 1. A write to either address while the bit is 0 changes nothing and does not restart the counters.
- R7: An accepted divisor-byte write or any oversampling-field write restarts both counters at that clock edge. The first following sample strobe comes D cycles later and the first bit strobe comes D·N cycles later, both using the new settings.
- R8: A write to the control register (address 2) changes only the latch-enable bit and does not disturb the strobe timing.
- R9: `bit_stb` and `mid_stb` are single-cycle pulses: neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 control, 3 oversampling |
| wr_data | input | 8 | Write data |
| sample_stb | output | 1 | Oversampling tick enable |
| mid_stb | output | 1 | Centre-of-bit enable |
| bit_stb | output | 1 | End-of-bit enable |

## Verification
The bench targets the divisor value of 0. A design that did not clamp it would either stall the sample strobe or wrap through 65536 cycles. It programs the ratio field with 0, with a value inside the clamped band, and with an odd value above 8. A wrong decoder would stretch or shrink the bit period, or move the mid strobe by a whole sample. It writes divisor bytes while the latch-enable bit is clear, which catches a design that leaks the write or restarts its counters on an ignored write. It also changes the divisor and the ratio in the middle of a bit. A design without the restart would finish the old period on stale counts, and a late strobe would show it.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int OSR_FIELD_W = 5;
    localparam int RATIO_W     = OSR_FIELD_W + 1;
    localparam int ACCESS_BIT  = 7;

    typedef enum logic [1:0] {
        SEL_DIV_LO = 2'd0,
        SEL_DIV_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_OSR    = 2'd3
    } reg_sel_e;

    // Oversampling field decode: 0 -> 32, 1..8 -> 8, otherwise the field itself
    function automatic logic [RATIO_W-1:0] osr_ratio(input logic [OSR_FIELD_W-1:0] f);
        if (f == '0)
            return RATIO_W'(32);
        else if (f <= OSR_FIELD_W'(8))
            return RATIO_W'(8);
        else
            return {1'b0, f};
    endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RST_DIV = 1,
    parameter int RST_OSR = 0,
    localparam int DIV_W  = 2 * DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [DIV_W-1:0]       divisor,
    output logic [OSR_FIELD_W-1:0] osr_field,
    output logic                   access,
    output logic                   reload
);

    typedef struct packed {
        logic [DATA_W-1:0]      lo;
        logic [DATA_W-1:0]      hi;
        logic                   acc;
        logic [OSR_FIELD_W-1:0] fld;
    } cfg_t;

    localparam logic [DIV_W-1:0] RST_DIV_V = DIV_W'(RST_DIV);

    cfg_t cfg_d, cfg_q;
    logic reload_d;

    always_comb begin
        cfg_d    = cfg_q;
        reload_d = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_DIV_LO: if (cfg_q.acc) begin
                    cfg_d.lo = wr_data;
                    reload_d = 1'b1;
                end
                SEL_DIV_HI: if (cfg_q.acc) begin
                    cfg_d.hi = wr_data;
                    reload_d = 1'b1;
                end
                SEL_CTRL: cfg_d.acc = wr_data[ACCESS_BIT];
                SEL_OSR: begin
                    cfg_d.fld = wr_data[OSR_FIELD_W-1:0];
                    reload_d  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lo  <= RST_DIV_V[DATA_W-1:0];
            cfg_q.hi  <= RST_DIV_V[DIV_W-1:DATA_W];
            cfg_q.acc <= 1'b0;
            cfg_q.fld <= OSR_FIELD_W'(RST_OSR);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign divisor   = {cfg_q.hi, cfg_q.lo};
    assign osr_field = cfg_q.fld;
    assign access    = cfg_q.acc;
    assign reload    = reload_d;

endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick,
    output logic [DIV_W-1:0] count,
    output logic [DIV_W-1:0] div_eff
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    // zero divisor is run as one so the tick never stops
    assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    assign tick    = (pre_q.cnt == div_eff - DIV_W'(1));

    always_comb begin
        pre_d = pre_q;
        if (reload)
            pre_d.cnt = '0;
        else if (tick)
            pre_d.cnt = '0;
        else
            pre_d.cnt = pre_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end

    assign count = pre_q.cnt;

endmodule

// File: rtl/baud_osr_cnt.sv
module baud_osr_cnt
    import baud_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reload,
    input  logic                   tick,
    input  logic [OSR_FIELD_W-1:0] osr_field,
    output logic                   bit_stb,
    output logic                   mid_stb,
    output logic [RATIO_W-1:0]     count,
    output logic [RATIO_W-1:0]     ratio
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } smp_t;

    smp_t smp_d, smp_q;
    logic [RATIO_W-1:0] half;
    logic               last;

    assign ratio = osr_ratio(osr_field);
    assign half  = ratio >> 1;
    assign last  = (smp_q.cnt == ratio - RATIO_W'(1));

    always_comb begin
        smp_d = smp_q;
        if (reload)
            smp_d.cnt = '0;
        else if (tick)
            smp_d.cnt = last ? '0 : smp_q.cnt + RATIO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            smp_q <= '0;
        else
            smp_q <= smp_d;
    end

    assign bit_stb = tick && last;
    assign mid_stb = tick && (smp_q.cnt == half - RATIO_W'(1));
    assign count   = smp_q.cnt;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RST_DIV = 1,
    parameter int RST_OSR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_stb,
    output logic              mid_stb,
    output logic              bit_stb
);

    localparam int DIV_W = 2 * DATA_W;

    logic [DIV_W-1:0]       divisor;
    logic [DIV_W-1:0]       div_eff;
    logic [DIV_W-1:0]       pre_cnt;
    logic [OSR_FIELD_W-1:0] osr_field;
    logic [RATIO_W-1:0]     smp_cnt;
    logic [RATIO_W-1:0]     ratio;
    logic                   access;
    logic                   reload;
    logic                   tick;

    baud_regs #(
        .DATA_W (DATA_W),
        .RST_DIV(RST_DIV),
        .RST_OSR(RST_OSR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .divisor  (divisor),
        .osr_field(osr_field),
        .access   (access),
        .reload   (reload)
    );

    baud_div_cnt #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .divisor(divisor),
        .tick   (tick),
        .count  (pre_cnt),
        .div_eff(div_eff)
    );

    baud_osr_cnt u_osr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .tick     (tick),
        .osr_field(osr_field),
        .bit_stb  (bit_stb),
        .mid_stb  (mid_stb),
        .count    (smp_cnt),
        .ratio    (ratio)
    );

    assign sample_stb = tick;

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic               sample_stb,
    input  logic               mid_stb,
    input  logic               bit_stb,
    input  logic               access,
    input  logic               reload,
    input  logic [DIV_W-1:0]   divisor,
    input  logic [DIV_W-1:0]   div_eff,
    input  logic [DIV_W-1:0]   pre_cnt,
    input  logic [RATIO_W-1:0] smp_cnt,
    input  logic [RATIO_W-1:0] ratio
);

    logic locked_div_wr;
    assign locked_div_wr = wr_en && !access && (wr_addr[1] == 1'b0);

    // R2: prescale count stays below the effective divisor
    assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt < div_eff);

    // R3: sample count stays below the decoded ratio
    assert_smp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_cnt < ratio);

    assert_bit_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> sample_stb);

    assert_mid_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb |-> (sample_stb && !bit_stb));

    assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked_div_wr |=> $stable(divisor));

    assert_locked_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked_div_wr |-> !reload);

    assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (pre_cnt == '0 && smp_cnt == '0));

    assert_bit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    assert_mid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb |=> !mid_stb);

endmodule

bind baud_tick_gen baud_tick_chk #(
    .DIV_W(DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sample_stb(sample_stb),
    .mid_stb   (mid_stb),
    .bit_stb   (bit_stb),
    .access    (access),
    .reload    (reload),
    .divisor   (divisor),
    .div_eff   (div_eff),
    .pre_cnt   (pre_cnt),
    .smp_cnt   (smp_cnt),
    .ratio     (ratio)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_stb, mid_stb, bit_stb;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural reference state
    int m_lo = 1, m_hi = 0, m_acc = 0, m_fld = 0, m_t = 0;
    logic prev_bit = 1'b0, prev_mid = 1'b0;

    always #4 clk = ~clk;

    baud_tick_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sample_stb(sample_stb),
        .mid_stb   (mid_stb),
        .bit_stb   (bit_stb)
    );

    function automatic int ref_ratio(int f);
        if (f == 0) return 32;
        if (f < 9) return 8;
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 1; m_hi = 0; m_acc = 0; m_fld = 0; m_t = 0;
        end else if (wr_en && wr_addr == 2'd0 && m_acc == 1) begin
            m_lo = wr_data; m_t = 0;
        end else if (wr_en && wr_addr == 2'd1 && m_acc == 1) begin
            m_hi = wr_data; m_t = 0;
        end else if (wr_en && wr_addr == 2'd3) begin
            m_fld = wr_data % 32; m_t = 0;
        end else begin
            if (wr_en && wr_addr == 2'd2) m_acc = wr_data[7];
            m_t = m_t + 1;
        end
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0d actual=%b expected=%b", req, phase, m_t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int d, r, p;
        d = m_lo + 256 * m_hi;
        if (d == 0) d = 1;
        r = ref_ratio(m_fld);
        p = d * r;
        check("R2 sample_stb", sample_stb, ((m_t + 1) % d) == 0);
        check("R4 bit_stb", bit_stb, ((m_t + 1) % p) == 0);
        check("R5 mid_stb", mid_stb, ((m_t + 1) % p) == d * (r / 2));
        check("R9 bit pulse", bit_stb && prev_bit, 1'b0);
        check("R9 mid pulse", mid_stb && prev_mid, 1'b0);
        prev_bit = bit_stb;
        prev_mid = mid_stb;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        // R1: reset defaults, divisor 1 and ratio 32
        run(3);
        rst_n = 1'b1;
        run(80);
        // R8: opening the latch does not disturb timing
        phase = "R8";
        run(5);
        wr(2'd2, 8'h80);
        run(20);
        // R7: accepted divisor write restarts counters mid-bit
        phase = "R7";
        wr(2'd0, 8'd3);
        run(50);
        // R3: field 16 -> ratio 16
        phase = "R3";
        wr(2'd3, 8'd16);
        run(120);
        wr(2'd2, 8'h00);
        run(7);
        // R6: locked divisor writes ignored
        phase = "R6";
        wr(2'd0, 8'd5);
        run(13);
        wr(2'd1, 8'd2);
        run(100);
        // R3: clamped band and zero and odd values
        phase = "R3";
        wr(2'd3, 8'd4);
        run(60);
        wr(2'd3, 8'd1);
        run(30);
        wr(2'd3, 8'd0);
        run(200);
        wr(2'd3, 8'd9);
        run(80);
        wr(2'd3, 8'd31);
        run(200);
        // R2: divisor zero acts as one
        phase = "R2";
        wr(2'd2, 8'h80);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'd8);
        run(40);
        // R4: high byte used, divisor 256 ratio 8
        phase = "R4";
        wr(2'd2, 8'h80);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h00);
        run(2200);
        // R7: ratio change in the middle of a bit
        phase = "R7";
        wr(2'd2, 8'h80);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd2);
        run(11);
        wr(2'd3, 8'd12);
        run(30);
        wr(2'd0, 8'd5);
        run(150);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_up();
    end

endmodule